// File: doc/BRIEF.md
# Memory Parity Error Capture

This block sits beside a 16-bit memory and watches its read cycles. Each byte lane carries one parity bit, and parity is even: the eight data bits of a lane together with that lane's parity bit must hold an even number of ones. When a read fails the check and no error is pending, the block captures several fields. It stores the failing address in two registers: the upper bits go into the control register and the low sixteen bits into a register of their own. It also records which byte lane failed and whether the host or a bus master made the access. It then raises a pending flag.

The host reads the capture through three 16-bit registers. It enables the parity interrupt in the status register and clears the pending error by writing an acknowledge bit in the control register. The status register also carries the general interrupt flag of the memory controller and that flag's enable. Only the first error is kept. Errors that arrive while one is pending are dropped until the host acknowledges.

Top module: `parity_err_capture`

## Requirements
- R1: After reset the status, control and low-address registers all read zero, and both interrupt outputs are low.
- R2: A read is checked only when `rd_valid_i` is high. Lane 0 is data bits 7:0 with parity bit 0, and lane 1 is data bits 15:8 with parity bit 1. A lane fails when its nine bits hold an odd number of ones. A read where no lane fails leaves every register unchanged.
- R3: On a failing read with no error pending, from the next clock the following hold: status bit 9 reads 1, control bits 3:0 hold address bits 19:16, and the low-address register holds address bits 15:0.
- R4: Control bit 6 gives the failing lane: 0 when lane 0 failed and 1 when only lane 1 failed. When both lanes fail it reads 0.
- R5: Control bit 7 holds `rd_src_i` of the failing read: 1 for a bus-master access and 0 for a host access.
- R6: While an error is pending, later failing reads leave status bit 9, control bits 7:0 and the low-address register unchanged.
- R7: A write to the control register with bit 8 set clears status bit 9 from the next clock. The captured fields keep their values. A control write with bit 8 clear has no effect, and control bit 8 always reads 0.
- R8: If a failing read and an acknowledge fall in the same cycle, the new error is captured: from the next clock status bit 9 reads 1 and the fields hold the new read.
- R9: `par_irq_o` is high exactly when status bit 9 and status bit 11 are both 1.
- R10: Status bit 8 reflects `gen_int_i`, and `gen_irq_o` is `gen_int_i` gated by status bit 12. A status write sets bits 11 and 12 only. All other status bits ignore writes.
- R11: Register select 0 is status, 1 is control and 2 is the low-address register. Select 3 reads zero. Reads are combinational on `reg_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | A memory read completes this cycle |
| rd_addr_i | input | 20 | Address of the read |
| rd_data_i | input | 16 | Data returned by the read |
| rd_par_i | input | 2 | Parity bits returned, one per byte lane |
| rd_src_i | input | 1 | 1 for a bus-master access, 0 for a host access |
| reg_we_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | Host register select |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data for the selected register |
| gen_int_i | input | 1 | General interrupt flag from the memory controller |
| gen_irq_o | output | 1 | General interrupt after its enable |
| par_irq_o | output | 1 | Parity error interrupt |

## Verification
A pending flag that sets wrongly or clears wrongly shows up at status bit 9 and `par_irq_o` one clock after the read or the acknowledge that caused it. Fields that are overwritten while an error is pending only show up when the host reads the control and low-address registers. For that reason every register is read back after every clock, and a corrupted capture is reported in the same cycle it occurs, not when the next acknowledge comes. The same-cycle acknowledge race and the two-lane failure give their answers in a single cycle, so both are driven as directed cases as well as inside the random traffic.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int REG_W   = 16;
  localparam int LO_W    = 16;
  localparam int HI_W    = 4;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_ADDR   = 2'd2;

  // status bit positions
  localparam int ST_GINT = 8;
  localparam int ST_PERR = 9;
  localparam int ST_PIEN = 11;
  localparam int ST_GIEN = 12;

  // control bit positions
  localparam int CT_ACK  = 8;
  localparam int CT_SRC  = 7;
  localparam int CT_SIDE = 6;

  typedef struct packed {
    logic            src;
    logic            side;
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } cap_t;
endpackage

// File: rtl/pec_lane_chk.sv
module pec_lane_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_i,
  input  logic         par_i,
  output logic         bad_o
);
  // even parity: odd count of ones over data plus parity bit is an error
  assign bad_o = ^{byte_i, par_i};
endmodule

// File: rtl/pec_capture.sv
module pec_capture
  import pec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  input  cap_t cap_i,
  output logic flag_o,
  output cap_t cap_o
);
  logic flag_q;
  cap_t cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else if (hit_i && (ack_i || !flag_q)) begin
      // ack clears first, so a same-cycle error is taken
      flag_q <= 1'b1;
      cap_q  <= cap_i;
    end else if (ack_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/pec_regs.sv
module pec_regs
  import pec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             gen_int_i,
  input  logic             flag_i,
  input  cap_t             cap_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             ack_o,
  output logic             pie_o,
  output logic             par_irq_o,
  output logic             gen_irq_o
);
  logic pie_q, gie_q;
  logic [REG_W-1:0] status_w, ctrl_w, addr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pie_q <= 1'b0;
      gie_q <= 1'b0;
    end else if (we_i && sel_i == SEL_STATUS) begin
      pie_q <= wdata_i[ST_PIEN];
      gie_q <= wdata_i[ST_GIEN];
    end
  end

  assign ack_o = we_i && (sel_i == SEL_CTRL) && wdata_i[CT_ACK];

  always_comb begin
    status_w          = '0;
    status_w[ST_GINT] = gen_int_i;
    status_w[ST_PERR] = flag_i;
    status_w[ST_PIEN] = pie_q;
    status_w[ST_GIEN] = gie_q;

    ctrl_w            = '0;
    ctrl_w[CT_SRC]    = cap_i.src;
    ctrl_w[CT_SIDE]   = cap_i.side;
    ctrl_w[HI_W-1:0]  = cap_i.hi;

    addr_w            = cap_i.lo;

    unique case (sel_i)
      SEL_STATUS: rdata_o = status_w;
      SEL_CTRL:   rdata_o = ctrl_w;
      SEL_ADDR:   rdata_o = addr_w;
      default:    rdata_o = '0;
    endcase
  end

  assign pie_o     = pie_q;
  assign par_irq_o = flag_i & pie_q;
  assign gen_irq_o = gen_int_i & gie_q;
endmodule

// File: rtl/parity_err_capture.sv
module parity_err_capture
  import pec_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W/8-1:0] rd_par_i,
  input  logic              rd_src_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              gen_int_i,
  output logic              gen_irq_o,
  output logic              par_irq_o
);
  localparam int LANES = DATA_W / 8;
  localparam int UP_W  = ADDR_W - LO_W;

  logic [LANES-1:0] lane_bad;
  logic             side_sel;
  logic             hit;
  logic             ack;
  logic             flag_q;
  logic             pe_en_q;
  cap_t             cap_in, cap_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pec_lane_chk #(.W(8)) u_lane (
      .byte_i (rd_data_i[g*8 +: 8]),
      .par_i  (rd_par_i[g]),
      .bad_o  (lane_bad[g])
    );
  end

  // lowest failing lane wins
  always_comb begin
    side_sel = 1'b0;
    for (int i = LANES - 1; i >= 0; i--)
      if (lane_bad[i]) side_sel = 1'(i);
  end

  assign hit = rd_valid_i && (|lane_bad);

  always_comb begin
    cap_in      = '0;
    cap_in.src  = rd_src_i;
    cap_in.side = side_sel;
    cap_in.hi   = HI_W'(rd_addr_i[ADDR_W-1 -: UP_W]);
    cap_in.lo   = rd_addr_i[LO_W-1:0];
  end

  pec_capture u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .ack_i  (ack),
    .cap_i  (cap_in),
    .flag_o (flag_q),
    .cap_o  (cap_q)
  );

  pec_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .gen_int_i (gen_int_i),
    .flag_i    (flag_q),
    .cap_i     (cap_q),
    .rdata_o   (reg_rdata_o),
    .ack_o     (ack),
    .pie_o     (pe_en_q),
    .par_irq_o (par_irq_o),
    .gen_irq_o (gen_irq_o)
  );
endmodule

// File: rtl/parity_err_capture_chk.sv
module parity_err_capture_chk
  import pec_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic [DATA_W/8-1:0] rd_par_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              par_irq_o,
  input logic              flag_q,
  input logic              pe_en_q,
  input cap_t              cap_q
);
  logic err_now, ack_now;
  assign err_now = rd_valid_i && ((^{rd_data_i[7:0], rd_par_i[0]}) ||
                                  (^{rd_data_i[15:8], rd_par_i[1]}));
  assign ack_now = reg_we_i && reg_sel_i == SEL_CTRL && reg_wdata_i[CT_ACK];

  assert_sets_on_error_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_now && !flag_q) |=> flag_q);

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !err_now) |=> !flag_q);

  assert_first_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_now) |=> (flag_q && $stable(cap_q)));

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_now && !err_now) |=> !flag_q);

  assert_race_capture_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_now && err_now) |=> flag_q);

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pe_en_q || !flag_q) |-> !par_irq_o);
endmodule

bind parity_err_capture parity_err_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_valid_i  (rd_valid_i),
  .rd_data_i   (rd_data_i),
  .rd_par_i    (rd_par_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .par_irq_o   (par_irq_o),
  .flag_q      (flag_q),
  .pe_en_q     (pe_en_q),
  .cap_q       (cap_q)
);

// File: tb/parity_err_capture_bench.sv
module parity_err_capture_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [15:0] rd_data = '0;
  logic [1:0]  rd_par = '0;
  logic        rd_src = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        gen_int = 1'b0;
  logic        gen_irq, par_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  bit         m_flag, m_pie, m_gie, m_src, m_side;
  bit [3:0]   m_hi;
  bit [15:0]  m_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_err_capture u_parity_err_capture (
    .clk_i(clk), .rst_ni(rst_n), .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .rd_data_i(rd_data), .rd_par_i(rd_par), .rd_src_i(rd_src),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .gen_int_i(gen_int), .gen_irq_o(gen_irq),
    .par_irq_o(par_irq)
  );

  function automatic logic [1:0] good_par(input logic [15:0] d);
    return {^d[15:8], ^d[7:0]};
  endfunction

  function automatic logic [15:0] exp_reg(input int k);
    logic [15:0] v = '0;
    case (k)
      0: begin v[8] = gen_int; v[9] = m_flag; v[11] = m_pie; v[12] = m_gie; end
      1: begin v[7] = m_src; v[6] = m_side; v[3:0] = m_hi; end
      2: v = m_lo;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [1:0] keep = reg_sel;
    for (int k = 0; k < 4; k++) begin
      reg_sel = 2'(k);
      #1;
      check($sformatf("%s R11 reg%0d", tag, k), reg_rdata, exp_reg(k));
    end
    check({tag, " R9 par_irq"}, {15'b0, par_irq}, {15'b0, m_flag & m_pie});
    check({tag, " R10 gen_irq"}, {15'b0, gen_irq}, {15'b0, gen_int & m_gie});
    reg_sel = keep;
  endtask

  task automatic model_step();
    bit lb0, lb1, err, ack;
    lb0 = ^{rd_data[7:0], rd_par[0]};
    lb1 = ^{rd_data[15:8], rd_par[1]};
    err = rd_valid && (lb0 || lb1);
    ack = reg_we && reg_sel == 2'd1 && reg_wdata[8];
    if (reg_we && reg_sel == 2'd0) begin
      m_pie = reg_wdata[11];
      m_gie = reg_wdata[12];
    end
    if (ack) m_flag = 0;
    if (err && !m_flag) begin
      m_flag = 1;
      m_src  = rd_src;
      m_side = lb0 ? 1'b0 : 1'b1;
      m_hi   = rd_addr[19:16];
      m_lo   = rd_addr[15:0];
    end
  endtask

  task automatic cyc(input string tag, input bit v, input logic [19:0] a,
                     input logic [15:0] d, input logic [1:0] pflip, input bit s,
                     input bit we, input logic [1:0] sel, input logic [15:0] wd,
                     input bit gi);
    rd_valid = v; rd_addr = a; rd_data = d; rd_par = good_par(d) ^ pflip;
    rd_src = s; reg_we = we; reg_sel = sel; reg_wdata = wd; gen_int = gi;
    @(posedge clk);
    model_step();
    @(negedge clk);
    rd_valid = 0; reg_we = 0;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    compare_all("R1 reset");
    @(negedge clk);
    rst_n = 1;
    compare_all("R1 after release");

    // R10: status write of enables, other bits ignored
    cyc("R10 enables", 0, 0, 0, 0, 0, 1, 0, 16'hFFFF, 1);
    cyc("R10 gen off", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: clean reads, invalid reads with bad parity
    cyc("R2 clean", 1, 20'hA1234, 16'hBEEF, 2'b00, 0, 0, 0, 0, 0);
    cyc("R2 not valid", 0, 20'h51111, 16'h00FF, 2'b11, 0, 0, 0, 0, 0);
    // R3 R4 R5: low lane error by host
    cyc("R3 R4 low lane", 1, 20'h7C0DE, 16'h1234, 2'b01, 0, 0, 0, 0, 0);
    // R6: later error dropped
    cyc("R6 held", 1, 20'h3FFFF, 16'h5555, 2'b10, 1, 0, 0, 0, 0);
    // R7: ack bit clear does nothing; ack bit set clears
    cyc("R7 no ack", 0, 0, 0, 0, 0, 1, 1, 16'h00FF, 0);
    cyc("R7 ack", 0, 0, 0, 0, 0, 1, 1, 16'h0100, 0);
    // R4 R5: high lane only, bus master
    cyc("R4 R5 high lane", 1, 20'hE8001, 16'hA5A5, 2'b10, 1, 0, 0, 0, 0);
    cyc("R7 ack2", 0, 0, 0, 0, 0, 1, 1, 16'hFFFF, 0);
    // R4: both lanes fail
    cyc("R4 both", 1, 20'h20002, 16'h0F0F, 2'b11, 0, 0, 0, 0, 1);
    // R8: ack and error in same cycle
    rd_addr = 20'h9ABCD;
    cyc("R8 race", 1, 20'h9ABCD, 16'hC3C3, 2'b10, 1, 1, 1, 16'h0100, 0);
    // R9: disable parity interrupt while pending
    cyc("R9 mask", 0, 0, 0, 0, 0, 1, 0, 16'h1000, 1);
    cyc("R9 unmask", 0, 0, 0, 0, 0, 1, 0, 16'h0800, 1);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0] fl = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      bit w = ($urandom_range(0, 5) == 0);
      logic [15:0] wd = 16'($urandom);
      cyc("R2 R3 R6 R7 R8 rand", 1'($urandom), 20'($urandom), 16'($urandom), fl,
          1'($urandom), w, 2'($urandom), wd, 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule